// File: doc/BRIEF.md
# Folded Biquad Recursive Filter

This block is a second-order recursive filter built with one adder and one constant-coefficient multiplier. The work for each sample (four constant multiplications and four additions) is spread over a fixed cycle of four clock slots. A two-bit slot counter decodes, for every slot, the multiplier coefficient, the adder operand selection and the addresses and write enables of two small register files. One register file has two cells and holds the two past values of the recursive state. The other has one cell and holds the current input sample until the adder needs it.

The filter computes the state `s[n] = x[n] + 0.2*s[n-1] + 0.4*s[n-2]` and the result `y[n] = s[n] + 0.3*s[n-1] + 0.6*s[n-2]`, with 16-bit Q1.15 data. The schedule runs freely from reset. A sample is taken in slot 0 of every period, once every four cycles. A source that streams continuously drives a new sample every fourth cycle, starting with the first cycle after reset is released. Each result leaves on a one-cycle valid strobe.

Top module: `fold_biquad`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `out_valid` is 0 and `out_data` is 0. The stored state and the held sample are zero, so the first sample sees `s[n-1] = s[n-2] = 0`.
- R2: The slot counter starts at 0 after reset and advances by one every cycle, modulo 4. `in_data` is captured only in slot 0, which falls on cycles 0, 4, 8, ... counted from the first clock edge after reset release. `in_valid` and `in_data` in slots 1 to 3 have no effect on any result.
- R3: When `in_valid` is 0 in slot 0, the filter processes a zero sample for that period. No `out_valid` pulse is produced for that period, and `out_data` keeps its previous value.
- R4: The state update is `s = x + r(s1*6554) + r(s2*13107)`, where 6554 and 13107 are the Q1.15 codes of 0.2 and 0.4. After the update, `s2` takes the old `s1` and `s1` takes `s`.
- R5: The result is `y = s + r(s1*9830) + r(s2*19661)`, using the state values from before the update. 9830 and 19661 are the Q1.15 codes of 0.3 and 0.6.
- R6: Every product is rounded as `r(p) = (p + 16384) >>> 15`, taking the low 16 bits of the 32-bit signed product sum. All additions wrap modulo 2^16 with no saturation.
- R7: For a sample captured in slot 0 of cycle c, `out_valid` is high for exactly one cycle, cycle c+7 (slot 3 of the following period). `out_valid` is never high in slots 0 to 2.
- R8: `out_data` changes only in a cycle where `out_valid` is high, and otherwise holds the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, looked at in slot 0 only |
| in_data | input | 16 | Input sample, Q1.15 two's complement |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 16 | Filter result, Q1.15 two's complement |

## Verification
On every cycle, the embedded assertions check how the slot counter steps and that the state pointer flips only in slot 0. They also check that the sample store loads in slot 0 (with zero when no sample is offered) and holds at all other times, and that the output strobe lasts one cycle, falls only in slot 3 and is the only time the output value changes. The numerical correctness of the recurrence, the order of coefficients within a period, the rounding of each product and the seven-cycle latency can only be shown by the scenarios. These compare every result against an independent bit-accurate model over an impulse, a step, random samples, and streams with missing samples and noise in the idle slots.

// File: rtl/fold_biquad_pkg.sv
package fold_biquad_pkg;

    typedef enum logic [1:0] {
        SLOT_0 = 2'd0,
        SLOT_1 = 2'd1,
        SLOT_2 = 2'd2,
        SLOT_3 = 2'd3
    } slot_e;

    // adder second operand: its own registered result, or the held sample
    typedef enum logic {
        ADDB_FEEDBACK = 1'b0,
        ADDB_SAMPLE   = 1'b1
    } addb_sel_e;

    // which constant the multiplier applies in a slot
    typedef enum logic [1:0] {
        CF_REC_NEAR  = 2'd0,  // 0.2 on s[n-1]
        CF_REC_FAR   = 2'd1,  // 0.4 on s[n-2]
        CF_OUT_NEAR  = 2'd2,  // 0.3 on s[n-1]
        CF_OUT_FAR   = 2'd3   // 0.6 on s[n-2]
    } coef_sel_e;

    typedef struct packed {
        coef_sel_e coef;
        logic      rd_older;
        logic      st_we;
        logic      x_we;
        addb_sel_e addb;
        logic      out_load;
    } sched_t;

    typedef struct packed {
        slot_e slot;
        logic  ptr;
    } ctrl_state_t;

endpackage

// File: rtl/fold_biquad_ctrl.sv
module fold_biquad_ctrl
    import fold_biquad_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output slot_e  slot,
    output sched_t sched,
    output logic   st_waddr,
    output logic   st_raddr
);

    ctrl_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.slot = slot_e'(2'(state_q.slot + 2'd1));
        if (state_q.slot == SLOT_0) begin
            state_d.ptr = ~state_q.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{slot: SLOT_0, ptr: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    // slot decode: coefficient order 0.4, 0.2, 0.6, 0.3 keeps every stored
    // value inside one period
    always_comb begin
        sched = '{coef: CF_REC_NEAR, rd_older: 1'b0, st_we: 1'b0,
                  x_we: 1'b0, addb: ADDB_FEEDBACK, out_load: 1'b0};
        unique case (state_q.slot)
            SLOT_0: begin
                sched.coef  = CF_REC_FAR;
                sched.st_we = 1'b1;
                sched.x_we  = 1'b1;
            end
            SLOT_1: begin
                sched.coef = CF_REC_NEAR;
            end
            SLOT_2: begin
                sched.coef     = CF_OUT_FAR;
                sched.rd_older = 1'b1;
                sched.addb     = ADDB_SAMPLE;
                sched.out_load = 1'b1;
            end
            SLOT_3: begin
                sched.coef = CF_OUT_NEAR;
            end
            default: ;
        endcase
    end

    assign slot     = state_q.slot;
    assign st_waddr = ~state_q.ptr;
    assign st_raddr = sched.rd_older ? ~state_q.ptr : state_q.ptr;

    logic [1:0] slot_bits;
    assign slot_bits = state_q.slot;

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_bits == 2'($past(slot_bits) + 2'd1)); // R2

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.slot != SLOT_0) |=> $stable(state_q.ptr)); // R4

endmodule

// File: rtl/fold_biquad_regfile.sv
module fold_biquad_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cell_q [DEPTH];
    logic [WIDTH-1:0] cell_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_comb begin
            cell_d[i] = cell_q[i];
            if (we && (waddr == AW'(i))) begin
                cell_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q[i] <= '0;
            end else begin
                cell_q[i] <= cell_d[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (raddr == AW'(j)) begin
                rdata = cell_q[j];
            end
        end
    end

endmodule

// File: rtl/fold_biquad_mul.sv
module fold_biquad_mul #(
    parameter int WIDTH = 16,
    parameter int FRAC  = 15,
    localparam int PW   = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op,
    input  logic [WIDTH-1:0] coef,
    output logic [WIDTH-1:0] res
);

    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

    typedef struct packed {
        logic signed [PW-1:0] prod;
        logic [WIDTH-1:0]     rounded;
    } mul_pipe_t;

    mul_pipe_t pipe_d, pipe_q;
    logic signed [PW-1:0] rsum;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.prod = PW'($signed(op)) * PW'($signed(coef));
        rsum        = pipe_q.prod + HALF;
        pipe_d.rounded = WIDTH'(rsum >>> FRAC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign res = pipe_q.rounded;

endmodule

// File: rtl/fold_biquad.sv
module fold_biquad
    import fold_biquad_pkg::*;
#(
    parameter int               DATA_W  = 16,
    parameter int               FRAC_W  = 15,
    parameter logic [DATA_W-1:0] K_REC_NEAR = 16'd6554,
    parameter logic [DATA_W-1:0] K_REC_FAR  = 16'd13107,
    parameter logic [DATA_W-1:0] K_OUT_NEAR = 16'd9830,
    parameter logic [DATA_W-1:0] K_OUT_FAR  = 16'd19661
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int ST_CELLS = 2;
    localparam int X_CELLS  = 1;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              tag_cur;
        logic              tag_prev;
        logic              ovld;
        logic [DATA_W-1:0] odata;
    } dp_state_t;

    slot_e             slot;
    sched_t            sched;
    logic              st_waddr, st_raddr;
    logic [DATA_W-1:0] st_rdata, x_held, x_wdata;
    logic [DATA_W-1:0] coef, mul_res, add_b;
    dp_state_t         dp_d, dp_q;

    fold_biquad_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot),
        .sched    (sched),
        .st_waddr (st_waddr),
        .st_raddr (st_raddr)
    );

    // two past state values, written with the newest state each period
    fold_biquad_regfile #(.WIDTH(DATA_W), .DEPTH(ST_CELLS)) u_state_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sched.st_we),
        .waddr (st_waddr),
        .wdata (dp_q.acc),
        .raddr (st_raddr),
        .rdata (st_rdata)
    );

    assign x_wdata = in_valid ? in_data : '0;

    fold_biquad_regfile #(.WIDTH(DATA_W), .DEPTH(X_CELLS)) u_sample_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sched.x_we),
        .waddr (1'b0),
        .wdata (x_wdata),
        .raddr (1'b0),
        .rdata (x_held)
    );

    always_comb begin
        unique case (sched.coef)
            CF_REC_NEAR: coef = K_REC_NEAR;
            CF_REC_FAR:  coef = K_REC_FAR;
            CF_OUT_NEAR: coef = K_OUT_NEAR;
            CF_OUT_FAR:  coef = K_OUT_FAR;
            default:     coef = '0;
        endcase
    end

    fold_biquad_mul #(.WIDTH(DATA_W), .FRAC(FRAC_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (st_rdata),
        .coef  (coef),
        .res   (mul_res)
    );

    always_comb begin
        dp_d  = dp_q;
        add_b = (sched.addb == ADDB_SAMPLE) ? x_held : dp_q.acc;
        dp_d.acc = mul_res + add_b;
        if (sched.x_we) begin
            dp_d.tag_prev = dp_q.tag_cur;
            dp_d.tag_cur  = in_valid;
        end
        dp_d.ovld = sched.out_load && dp_q.tag_prev;
        if (sched.out_load && dp_q.tag_prev) begin
            dp_d.odata = dp_q.acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign out_valid = dp_q.ovld;
    assign out_data  = dp_q.odata;

    AST_SAMPLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_0 && in_valid) |=> (x_held == $past(in_data))); // R2

    AST_SAMPLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != SLOT_0) |=> $stable(x_held)); // R2

    AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_0 && !in_valid) |=> (x_held == '0)); // R3

    AST_OUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (slot == SLOT_3)); // R7

    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R8

endmodule

// File: tb/fold_biquad_bench.sv
module fold_biquad_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic signed [15:0] m_s1 = '0;
    logic signed [15:0] m_s2 = '0;
    bit          prev_v = 1'b0;
    logic [15:0] prev_y = '0;
    logic [15:0] last_out = '0;

    always #2 clk = ~clk;

    fold_biquad u_fold_biquad (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R6: rounded Q1.15 product
    function automatic logic signed [15:0] rnd(input logic signed [15:0] a,
                                               input logic signed [15:0] c);
        logic signed [31:0] p;
        p = a * c;
        p = p + 32'sd16384;
        return 16'(p >>> 15);
    endfunction

    // R4, R5: one sample through the model
    function automatic logic [15:0] model_step(input logic [15:0] x);
        logic [15:0] s, y;
        s = x + rnd(m_s1, 16'sd6554) + rnd(m_s2, 16'sd13107);
        y = s + rnd(m_s1, 16'sd9830) + rnd(m_s2, 16'sd19661);
        m_s2 = m_s1;
        m_s1 = s;
        return y;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one schedule period; called at the negedge before a slot-0 edge
    task automatic period(input bit v, input logic [15:0] x, input bit junk,
                          input string req);
        logic [15:0] cur_y;
        check("R7 no strobe in slot 0", 32'(out_valid), 32'd0);
        check("R8 hold in slot 0", 32'(out_data), 32'(last_out));
        in_valid = v;
        in_data  = x;
        cur_y    = model_step(v ? x : 16'd0);
        for (int k = 1; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            in_valid = junk;
            in_data  = 16'($urandom);
            if (out_valid !== 1'b0) begin
                check("R7 no strobe in slot 1/2", 32'(out_valid), 32'd0);
            end
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = junk;
        in_data  = 16'($urandom);
        check({req, " strobe"}, 32'(out_valid), 32'(prev_v));
        if (prev_v) begin
            check({req, " value"}, 32'(out_data), 32'(prev_y));
            last_out = prev_y;
        end else begin
            check("R3 value held", 32'(out_data), 32'(last_out));
        end
        prev_v = v;
        prev_y = cur_y;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", 32'(out_valid), 32'd0);
        check("R1 out_data in reset", 32'(out_data), 32'd0);
        rst_n = 1'b1;
        check("R1 out_valid after release", 32'(out_valid), 32'd0);
    endtask

    task automatic test_impulse();
        period(1'b1, 16'h4000, 1'b0, "R4 impulse");
        for (int i = 0; i < 10; i++) period(1'b1, 16'h0000, 1'b0, "R5 impulse tail");
    endtask

    task automatic test_step();
        for (int i = 0; i < 14; i++) period(1'b1, 16'h1000, 1'b1, "R2 step with idle noise");
    endtask

    task automatic test_random();
        for (int i = 0; i < 24; i++) period(1'b1, 16'($urandom), 1'b1, "R6 random");
    endtask

    task automatic test_gaps();
        for (int i = 0; i < 20; i++) period(1'($urandom), 16'($urandom), 1'b1, "R3 gaps");
        period(1'b0, 16'h7fff, 1'b1, "R3 flush");
        period(1'b0, 16'h0000, 1'b0, "R8 flush");
    endtask

    initial begin
        test_reset();
        test_impulse();
        test_step();
        test_random();
        test_gaps();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule